// File: doc/BRIEF.md
# Two-Rate Serial Register Bus Master

This block connects a parallel register port on the microcontroller side to an external serial register bus. A transaction always starts with one address byte. In a write, a data byte follows it directly, with no idle bit between the two bytes. In a read, the master sends the address and then clocks in one byte from the addressed location. The master drives the serial clock. Bits go out least-significant first. Data changes while the clock is low and is sampled when the clock rises.

The host presents the read/write select, the address, the write data and a rate select, then pulses `start`. `busy` stays high for the whole frame. A one-cycle `done` pulse follows. In a read, the received byte is present in `rdata` during that pulse. Two bit rates are available: a slow rate of `SLOW_DIV` system clocks per bit and a fast rate of `FAST_DIV` clocks per bit. With a 16 MHz system clock, the defaults of 16 and 8 give 1 and 2 Mbit/s. The rate the host selects is copied into the block only while the bus is idle, so a frame that is already running keeps its rate.

Top module: `serreg_master`

## Requirements
- R1: After reset `busy` and `done` are 0, `sclk` and `sdo` are 1 (the idle level), `rdata` is 0, and the slow rate is in effect.
- R2: A `start` pulse while idle begins a frame of AW+DW bits. Each bit lasts `SLOW_DIV` cycles when `rate_sel`=0 and `FAST_DIV` cycles when `rate_sel`=1. `rate_sel` is taken at the start cycle.
- R3: In each bit, `sclk` is low for the first half of the bit period and high for the second half. `sdo` changes only while `sclk` is low.
- R4: In a write (`rd_nwr`=0), the frame carries `addr` bits 0..AW-1 and then `wdata` bits 0..DW-1, each field least-significant bit first, with the data immediately after the address.
- R5: In a read (`rd_nwr`=1), the frame carries `addr` least-significant bit first, then holds `sdo` at 1 for DW bits. During those bits, `sdi` is sampled on each rising `sclk` and assembled least-significant bit first.
- R6: `busy` is 1 for exactly (AW+DW) bit periods, starting the cycle after `start` is accepted. A `start` that arrives while `busy` is 1 is ignored.
- R7: `done` is 1 for exactly one cycle, the cycle right after `busy` falls. In a read, `rdata` holds the received byte from that cycle until the next read completes.
- R8: A change of `rate_sel` while `busy` is 1 does not change the bit period of the running frame. The new value takes effect at the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a transaction (accepted only when idle) |
| rd_nwr | input | 1 | 1 = read, 0 = write |
| rate_sel | input | 1 | 0 = slow rate, 1 = fast rate |
| addr | input | AW | Address byte to send |
| wdata | input | DW | Data byte for a write |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| rdata | output | DW | Byte received by the last read |
| sclk | output | 1 | Serial clock, idle high |
| sdo | output | 1 | Serial data out, idle high |
| sdi | input | 1 | Serial data in |

## Verification
The bench builds the block with `SLOW_DIV`=8 and `FAST_DIV`=4. This keeps frames short enough to run many of them, and the two rates still differ by a factor of two, so a frame timed at the wrong rate is caught. With AW=DW=8, the byte boundary between address and data lies inside every frame, so any gap or repeated bit there shows up as a wrong bit count or a wrong duration. Toggling the rate in the middle of a frame and pulsing `start` during a frame make it possible to check that the running frame keeps its timing.

// File: rtl/serreg_master.sv
module serreg_master #(
  parameter int SLOW_DIV = 16,
  parameter int FAST_DIV = 8,
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          rd_nwr,
  input  logic          rate_sel,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] rdata,
  output logic          sclk,
  output logic          sdo,
  input  logic          sdi
);
  localparam int FW = AW + DW;
  localparam int CW = $clog2(SLOW_DIV);
  localparam int BW = $clog2(FW);

  logic          rate_q, rd_q;
  logic [CW-1:0] cnt;
  logic [BW-1:0] bidx;
  logic [FW-1:0] sh;
  logic [DW-1:0] rx;
  logic [CW-1:0] last, half;

  assign last = rate_q ? CW'(FAST_DIV - 1) : CW'(SLOW_DIV - 1);
  assign half = rate_q ? CW'(FAST_DIV / 2) : CW'(SLOW_DIV / 2);
  assign sclk = ~busy | (cnt >= half);
  assign sdo  = ~busy | sh[0];

  wire bit_end   = busy && (cnt == last);
  wire frame_end = bit_end && (bidx == BW'(FW - 1));
  wire sample    = busy && (cnt == half - 1'b1) && (bidx >= BW'(AW));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate_q <= 1'b0;
      rd_q   <= 1'b0;
      busy   <= 1'b0;
      done   <= 1'b0;
      cnt    <= '0;
      bidx   <= '0;
      sh     <= '1;
      rx     <= '0;
      rdata  <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        rate_q <= rate_sel;
        if (start) begin
          busy <= 1'b1;
          rd_q <= rd_nwr;
          cnt  <= '0;
          bidx <= '0;
          sh   <= rd_nwr ? {{DW{1'b1}}, addr} : {wdata, addr};
        end
      end else begin
        cnt <= bit_end ? '0 : cnt + 1'b1;
        if (sample) rx <= {sdi, rx[DW-1:1]};
        if (bit_end) begin
          bidx <= bidx + 1'b1;
          sh   <= {1'b1, sh[FW-1:1]};
        end
        if (frame_end) begin
          busy <= 1'b0;
          done <= 1'b1;
          if (rd_q) rdata <= rx;
        end
      end
    end
  end

  p_idle_lines_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sclk && sdo));
  p_sdo_moves_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$stable(sdo)) |-> !sclk);
  p_rate_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(rate_q));
  p_done_follows_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_no_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !frame_end) |=> busy);
  p_rx_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(rdata));
endmodule

// File: tb/tb_serreg_master.sv
module tb_serreg_master;
  localparam int SD = 8, FD = 4, AW = 8, DW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, rd_nwr = 0, rate_sel = 0, sdi = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic busy, done, sclk, sdo;
  logic [DW-1:0] rdata;

  int checks = 0, errors = 0;
  int rcnt;
  logic [15:0] cap;
  logic slave_rd;
  logic [7:0] slave_byte;

  always #5 clk = ~clk;

  serreg_master #(.SLOW_DIV(SD), .FAST_DIV(FD), .AW(AW), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .rd_nwr(rd_nwr), .rate_sel(rate_sel),
    .addr(addr), .wdata(wdata), .busy(busy), .done(done), .rdata(rdata),
    .sclk(sclk), .sdo(sdo), .sdi(sdi));

  function automatic logic [7:0] mem_of(input logic [7:0] a);
    return (a * 8'd37) ^ 8'h5A;
  endfunction

  always @(posedge sclk) if (rst_n && busy) begin
    if (rcnt < 16) cap[rcnt] = sdo;
    rcnt = rcnt + 1;
  end

  always @(negedge sclk) if (rst_n && busy) begin
    if (slave_rd && rcnt >= 8 && rcnt < 16) sdi = slave_byte[rcnt-8];
    else sdi = 1'b1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic txn(input bit rd, input logic [7:0] a, input logic [7:0] d,
                     input bit fast, input bit toggle, input bit restart);
    int n = 0;
    int p = fast ? FD : SD;
    logic [15:0] exp_bits = rd ? {8'hFF, a} : {d, a};
    @(negedge clk);
    rate_sel = fast; rd_nwr = rd; addr = a; wdata = d;
    rcnt = 0; cap = '0; slave_rd = rd; slave_byte = mem_of(a);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1, "R2 busy after start", busy, 1);
    while (busy === 1'b1 && n < 1000) begin
      if (toggle && n == 3) rate_sel = ~fast;
      start = (restart && n == 5);
      @(negedge clk);
      n++;
    end
    start = 1'b0;
    chk(n == 16 * p, toggle ? "R8 duration under rate toggle" :
        (restart ? "R6 duration with start while busy" : "R2 R6 frame duration"), n, 16 * p);
    chk(done === 1'b1, "R7 done after busy", done, 1);
    chk(rcnt == 16, "R3 sclk rising edges", rcnt, 16);
    chk(cap === exp_bits, rd ? "R5 read frame bits" : "R4 write frame bits", cap, exp_bits);
    if (rd) chk(rdata === mem_of(a), "R5 R7 rdata", rdata, mem_of(a));
    @(negedge clk);
    chk(done === 1'b0, "R7 done one cycle", done, 0);
    chk(busy === 1'b0, "R6 no restart", busy, 0);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] last_rd;
    process::self().srandom(32'd1234);
    repeat (3) @(negedge clk);
    chk(busy === 0 && done === 0, "R1 busy/done reset", {busy, done}, 0);
    chk(sclk === 1 && sdo === 1, "R1 idle lines", {sclk, sdo}, 3);
    chk(rdata === '0, "R1 rdata reset", rdata, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(sclk === 1 && sdo === 1, "R1 idle after reset", {sclk, sdo}, 3);
    txn(0, 8'h00, 8'hFF, 0, 0, 0);
    txn(0, 8'hFF, 8'h00, 1, 0, 0);
    txn(1, 8'h80, 8'h00, 0, 0, 0);
    last_rd = 8'h80;
    txn(0, 8'h3C, 8'hA5, 0, 0, 0);
    chk(rdata === mem_of(last_rd), "R7 rdata held over write", rdata, mem_of(last_rd));
    txn(0, 8'h12, 8'h34, 0, 1, 0);
    txn(1, 8'h01, 8'h00, 1, 1, 0);
    txn(0, 8'h55, 8'hAA, 1, 0, 1);
    txn(1, 8'hC3, 8'h00, 0, 0, 1);
    for (int i = 0; i < 40; i++) begin
      bit r = 1'($urandom);
      txn(r, 8'($urandom), 8'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule